// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits between a link receiver core and a flat-panel output pad ring. It receives one decoded pixel per clock, 8 bits for each of three color channels, with a data-enable, horizontal and vertical sync and three general control bits. It presents them on a 36-bit panel bus in one of two layouts. In single mode the whole 24-bit pixel goes out every clock. In dual mode two consecutive pixels are cut to 6 bits per channel and placed side by side on the bus. The bus then updates at half the pixel rate.

An output clock enable shows in which pixel-clock cycles the panel clock pulses. For passive-matrix panels that enable can be forced off while the output data-enable is low. A registered polarity flag tells the pad logic whether the panel latches on the rising or the falling clock edge. Two active-low disable inputs drive an output-enable vector that models the tri-state pads. All configuration inputs are static and are changed only under reset.

Top module: `dual_pixel_out_fmt`

## Requirements
- R1: With `cfg_dual` low, one cycle after a pixel is presented `q_data[23:0]` equals `pix_in` and `q_data[35:24]` is zero. `pix_in` carries channel 0 in bits 7:0, channel 1 in bits 15:8 and channel 2 in bits 23:16.
- R2: With `cfg_dual` high, each pixel is reduced to its upper 6 bits per channel and packed as channel 0 in the low 6 bits, then channel 1, then channel 2. The even pixel of a pair occupies `q_data[17:0]` and the odd pixel occupies `q_data[35:18]`.
- R3: In dual mode, the first pixel after every rising edge of `de_in` is treated as an even pixel, whatever the phase of the pairing before it. Outside that case, even and odd slots alternate every cycle.
- R4: In dual mode the bus, `q_de`, `q_hs`, `q_vs` and `q_ctl` change only one cycle after an odd slot. At that point the sync and control outputs take the values presented with the odd pixel. In all other cycles they hold.
- R5: With gating off, `oclk_en` is high every cycle in single mode. In dual mode it is high only in the cycle after an odd slot, that is, every second cycle.
- R6: With `cfg_gate_blank` high, `oclk_en` is low whenever the output `q_de` is low. With it low, the clock enable ignores DE.
- R7: `oclk_inv` follows `cfg_clk_inv` with one cycle of latency. High means the panel latches on the rising edge.
- R8: One cycle after `pwr_n` is low, every bit of `out_oe` is zero.
- R9: One cycle after `out_dis_n` is low with `pwr_n` high, `out_oe` equals 8'h20. Only bit 5, which enables control bit 0, stays set. Bit order: 0 bus, 1 DE, 2 HSYNC, 3 VSYNC, 4 clock, 5..7 control bits 0..2. With both inputs high, `out_oe` is 8'hFF.
- R10: While `rst` is high, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 0: one pixel per clock, 1: two pixels per output clock |
| cfg_clk_inv | input | 1 | Output clock polarity select |
| cfg_gate_blank | input | 1 | Stop output clock while DE is low |
| pwr_n | input | 1 | Active-low full power-down |
| out_dis_n | input | 1 | Active-low output disable (control bit 0 exempt) |
| pix_in | input | 24 | Decoded pixel, three 8-bit channels |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ctl_in | input | 3 | General control bits |
| q_data | output | 36 | Panel data bus |
| q_de | output | 1 | Registered data enable |
| q_hs | output | 1 | Registered horizontal sync |
| q_vs | output | 1 | Registered vertical sync |
| q_ctl | output | 3 | Registered control bits |
| oclk_en | output | 1 | Output clock pulses in this cycle |
| oclk_inv | output | 1 | Registered clock polarity |
| out_oe | output | 8 | Per-group output enables |

## Verification
Single mode is driven with distinct pixel values and toggling sync and control bits, which confirms the straight pass-through and the zero upper bus. Dual mode is driven with a line of six active pixels, then an odd-length blanking gap, then another line. The odd gap leaves the free-running pairing on the wrong phase, so only a correct restart on the DE edge produces the expected packing. Pixels whose low two bits differ from their upper bits separate proper truncation from a shifted or unshifted copy. The gated runs then show the clock enable dropping exactly in the blanking cycles in each mode, and separate power-down and disable sequences tell the exempt control enable apart from the rest.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int unsigned CTL_N  = 3;
  localparam int unsigned OE_W   = 8;
  localparam int unsigned OE_BUS = 0;
  localparam int unsigned OE_DE  = 1;
  localparam int unsigned OE_HS  = 2;
  localparam int unsigned OE_VS  = 3;
  localparam int unsigned OE_CLK = 4;
  localparam int unsigned OE_CTL0 = 5;

  typedef struct packed {
    logic             de;
    logic             hs;
    logic             vs;
    logic [CTL_N-1:0] ctl;
  } sync_t;
endpackage

// File: rtl/pof_phase.sv
// Tracks even/odd slot of dual-pixel pairing; restarts on DE rising edge.
module pof_phase (
  input  logic clk,
  input  logic rst,
  input  logic de_in,
  output logic even_slot
);
  logic de_q;
  logic odd_q;
  logic de_rise;

  assign de_rise   = de_in & ~de_q;
  assign even_slot = de_rise | ~odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      de_q  <= de_in;
      odd_q <= even_slot;
    end
  end
endmodule

// File: rtl/pof_narrow.sv
// Keeps the upper NW bits of each CH_W-bit channel.
module pof_narrow #(
  parameter int unsigned CH_W = 8,
  parameter int unsigned NW   = 6,
  parameter int unsigned NCH  = 3
) (
  input  logic [NCH*CH_W-1:0] wide_in,
  output logic [NCH*NW-1:0]   narrow_out
);
  localparam int unsigned DROP = CH_W - NW;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign narrow_out[c*NW +: NW] = wide_in[c*CH_W + DROP +: NW];
  end
endmodule

// File: rtl/pof_pack.sv
// Data path: single pass-through or even/odd pair packing, plus clock enable.
module pof_pack
  import pof_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  parameter int unsigned NW   = 6,
  parameter int unsigned NCH  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dual,
  input  logic                  gate,
  input  logic                  even_slot,
  input  logic [NCH*CH_W-1:0]   pix,
  input  sync_t                 sync_in,
  output logic [2*NCH*NW-1:0]   bus,
  output sync_t                 sync_out,
  output logic                  clk_en
);
  localparam int unsigned PIX_W = NCH * CH_W;
  localparam int unsigned NAR_W = NCH * NW;
  localparam int unsigned BUS_W = 2 * NAR_W;
  localparam int unsigned PAD_W = BUS_W - PIX_W;

  logic [NAR_W-1:0] nar;
  logic [NAR_W-1:0] even_hold;
  logic             en_next;

  pof_narrow #(.CH_W(CH_W), .NW(NW), .NCH(NCH)) u_narrow (
    .wide_in    (pix),
    .narrow_out (nar)
  );

  assign en_next = ~(gate & ~sync_in.de);

  always_ff @(posedge clk) begin
    if (rst) begin
      even_hold <= '0;
      bus       <= '0;
      sync_out  <= '0;
      clk_en    <= 1'b0;
    end else if (dual) begin
      if (even_slot) begin
        even_hold <= nar;
        clk_en    <= 1'b0;
      end else begin
        bus      <= {nar, even_hold};
        sync_out <= sync_in;
        clk_en   <= en_next;
      end
    end else begin
      bus      <= {{PAD_W{1'b0}}, pix};
      sync_out <= sync_in;
      clk_en   <= en_next;
    end
  end
endmodule

// File: rtl/pof_oe.sv
// Output-enable vector from the two active-low disables.
module pof_oe
  import pof_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pwr_n,
  input  logic            out_dis_n,
  output logic [OE_W-1:0] oe
);
  for (genvar i = 0; i < OE_W; i++) begin : g_oe
    localparam bit EXEMPT = (i == OE_CTL0);
    always_ff @(posedge clk) begin
      if (rst) oe[i] <= 1'b0;
      else     oe[i] <= pwr_n & (out_dis_n | EXEMPT);
    end
  end
endmodule

// File: rtl/dual_pixel_out_fmt.sv
module dual_pixel_out_fmt
  import pof_pkg::*;
#(
  parameter int unsigned CH_W = 8,
  parameter int unsigned NW   = 6,
  parameter int unsigned NCH  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_dual,
  input  logic                 cfg_clk_inv,
  input  logic                 cfg_gate_blank,
  input  logic                 pwr_n,
  input  logic                 out_dis_n,
  input  logic [NCH*CH_W-1:0]  pix_in,
  input  logic                 de_in,
  input  logic                 hs_in,
  input  logic                 vs_in,
  input  logic [CTL_N-1:0]     ctl_in,
  output logic [2*NCH*NW-1:0]  q_data,
  output logic                 q_de,
  output logic                 q_hs,
  output logic                 q_vs,
  output logic [CTL_N-1:0]     q_ctl,
  output logic                 oclk_en,
  output logic                 oclk_inv,
  output logic [OE_W-1:0]      out_oe
);
  logic  even_slot;
  sync_t sync_in;
  sync_t sync_q;

  assign sync_in = '{de: de_in, hs: hs_in, vs: vs_in, ctl: ctl_in};

  pof_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .de_in     (de_in),
    .even_slot (even_slot)
  );

  pof_pack #(.CH_W(CH_W), .NW(NW), .NCH(NCH)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .dual      (cfg_dual),
    .gate      (cfg_gate_blank),
    .even_slot (even_slot),
    .pix       (pix_in),
    .sync_in   (sync_in),
    .bus       (q_data),
    .sync_out  (sync_q),
    .clk_en    (oclk_en)
  );

  pof_oe u_oe (
    .clk       (clk),
    .rst       (rst),
    .pwr_n     (pwr_n),
    .out_dis_n (out_dis_n),
    .oe        (out_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) oclk_inv <= 1'b0;
    else     oclk_inv <= cfg_clk_inv;
  end

  assign q_de  = sync_q.de;
  assign q_hs  = sync_q.hs;
  assign q_vs  = sync_q.vs;
  assign q_ctl = sync_q.ctl;
endmodule

// File: rtl/dual_pixel_out_fmt_chk.sv
module dual_pixel_out_fmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_dual,
  input logic        cfg_clk_inv,
  input logic        cfg_gate_blank,
  input logic        pwr_n,
  input logic        out_dis_n,
  input logic [23:0] pix_in,
  input logic [35:0] q_data,
  input logic        q_de,
  input logic        oclk_en,
  input logic        oclk_inv,
  input logic [7:0]  out_oe
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_dual |=> q_data[35:24] == 12'h0);

  a_r1_pass: assert property (@(posedge clk) disable iff (rst)
    !cfg_dual |=> q_data[23:0] == $past(pix_in));

  a_r5_alternate: assert property (@(posedge clk) disable iff (rst)
    (cfg_dual && !cfg_gate_blank && oclk_en) |=> !oclk_en);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_dual && !cfg_gate_blank) |=> (oclk_en || $stable(q_data)));

  a_r6_gate: assert property (@(posedge clk) disable iff (rst)
    (cfg_gate_blank && !q_de) |-> !oclk_en);

  a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
    !rst |=> oclk_inv == $past(cfg_clk_inv));

  a_r8_powerdown: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> out_oe == 8'h00);

  a_r9_out_disable: assert property (@(posedge clk) disable iff (rst)
    (pwr_n && !out_dis_n) |=> out_oe == 8'h20);
endmodule

bind dual_pixel_out_fmt dual_pixel_out_fmt_chk u_chk (.*);

// File: tb/dual_pixel_out_fmt_bench.sv
module dual_pixel_out_fmt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dual = 1'b0, cfg_clk_inv = 1'b0, cfg_gate_blank = 1'b0;
  logic        pwr_n = 1'b1, out_dis_n = 1'b1;
  logic [23:0] pix_in = '0;
  logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [2:0]  ctl_in = '0;
  logic [35:0] q_data;
  logic        q_de, q_hs, q_vs, oclk_en, oclk_inv;
  logic [2:0]  q_ctl;
  logic [7:0]  out_oe;

  always #4 clk = ~clk;

  dual_pixel_out_fmt u_dual_pixel_out_fmt (.*);

  typedef struct {
    logic [35:0] data;
    logic [5:0]  sy;
    logic        en;
    logic        inv;
    logic [7:0]  oe;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  logic want_pwr = 1'b1, want_dis = 1'b1;

  logic        m_odd, m_de_prev;
  logic [17:0] m_even;
  logic [35:0] h_data;
  logic [5:0]  h_sy;
  logic        h_en;

  function automatic logic [17:0] trunc(input logic [23:0] p);
    return {p[23:18], p[15:10], p[7:2]};
  endfunction

  task automatic model_reset();
    m_odd = 0; m_de_prev = 0; m_even = '0; h_data = '0; h_sy = '0; h_en = 0;
  endtask

  task automatic drive(input logic [23:0] p, input logic de, input logic hs,
                       input logic vs, input logic [2:0] c, input string tag);
    exp_t e;
    logic rise, even;
    @(negedge clk);
    rst = 0; pix_in = p; de_in = de; hs_in = hs; vs_in = vs; ctl_in = c;
    pwr_n = want_pwr; out_dis_n = want_dis;
    if (cfg_dual) begin
      rise = de && !m_de_prev;
      even = rise || !m_odd;
      if (even) begin
        m_even = trunc(p);
        h_en = 0;
      end else begin
        h_data = {trunc(p), m_even};
        h_sy = {de, hs, vs, c};
        h_en = !(cfg_gate_blank && !de);
      end
      m_odd = even;
    end else begin
      h_data = {12'h000, p};
      h_sy = {de, hs, vs, c};
      h_en = !(cfg_gate_blank && !de);
    end
    m_de_prev = de;
    e.data = h_data; e.sy = h_sy; e.en = h_en; e.inv = cfg_clk_inv;
    e.oe = !want_pwr ? 8'h00 : (!want_dis ? 8'h20 : 8'hFF);
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares one expected item per clock, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] act_sy;
        e = q.pop_front();
        act_sy = {q_de, q_hs, q_vs, q_ctl};
        n_vec++;
        if (q_data !== e.data || act_sy !== e.sy || oclk_en !== e.en ||
            oclk_inv !== e.inv || out_oe !== e.oe) begin
          n_bad++;
          $display("FAIL %s: data=%h sync=%b en=%b inv=%b oe=%h expected data=%h sync=%b en=%b inv=%b oe=%h",
                   e.tag, q_data, act_sy, oclk_en, oclk_inv, out_oe,
                   e.data, e.sy, e.en, e.inv, e.oe);
        end
      end
    end
  end

  task automatic set_cfg(input logic dual, input logic inv, input logic gate);
    @(negedge clk);
    rst = 1; cfg_dual = dual; cfg_clk_inv = inv; cfg_gate_blank = gate;
    pix_in = '0; de_in = 0; hs_in = 0; vs_in = 0; ctl_in = '0;
    repeat (2) @(negedge clk);
    n_vec++;
    if (q_data !== '0 || q_de !== 0 || q_hs !== 0 || q_vs !== 0 || q_ctl !== '0 ||
        oclk_en !== 0 || oclk_inv !== 0 || out_oe !== '0) begin
      n_bad++;
      $display("FAIL R10: data=%h en=%b inv=%b oe=%h expected all zero",
               q_data, oclk_en, oclk_inv, out_oe);
    end
    model_reset();
  endtask

  task automatic line(input int n, input logic [23:0] base, input string tag);
    for (int i = 0; i < n; i++)
      drive(base + 24'h050B13 * i, 1'b1, 1'b0, 1'b0, 3'(i), tag);
  endtask

  task automatic blank(input int n, input string tag);
    for (int i = 0; i < n; i++)
      drive(24'hA5A5A5 ^ 24'(i), 1'b0, i[0], 1'b1, 3'(i + 2), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state, then R1 single-mode pass-through
    set_cfg(0, 0, 0);
    drive(24'h000000, 0, 0, 0, 3'b000, "R1");
    line(5, 24'h123456, "R1");
    blank(3, "R5");
    line(3, 24'hFEDCBA, "R1");
    // R6 gating in single mode
    set_cfg(0, 0, 1);
    blank(2, "R6");
    line(4, 24'h0F0F0F, "R6");
    blank(3, "R6");
    // R2 R3 R4 R5 dual packing, odd blanking gap forces restart on DE edge
    set_cfg(1, 0, 0);
    line(6, 24'h837261, "R2");
    blank(3, "R4");
    line(6, 24'h3D2C1B, "R3");
    blank(2, "R5");
    line(5, 24'hC3C3C3, "R3");
    blank(4, "R4");
    // R6 gating in dual mode
    set_cfg(1, 0, 1);
    blank(3, "R6");
    line(6, 24'h7F80FF, "R6");
    blank(5, "R6");
    // R7 polarity
    set_cfg(0, 1, 0);
    line(3, 24'h010203, "R7");
    // R8 R9 output enables
    want_pwr = 0; want_dis = 1;
    line(3, 24'h445566, "R8");
    want_pwr = 1; want_dis = 0;
    line(3, 24'h778899, "R9");
    want_pwr = 0; want_dis = 0;
    line(2, 24'h111111, "R8");
    want_pwr = 1; want_dis = 1;
    line(2, 24'h222222, "R9");
    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule